// File: doc/BRIEF.md
# Two-Wire Paged EEPROM Slave

This block is the slave side of a two-wire serial bus in front of a 16 Kbit byte-wide nonvolatile store. The store is held in on-chip registers. Both bus lines are oversampled on the system clock. The slave pulls SDA low through an open-drain enable, so it only ever drives a zero. A transfer opens with a device byte. That byte holds a fixed four-bit tag, three bits that pick one of eight 256-byte pages, and a direction bit. In a write, a word address byte and then data bytes follow.

Incoming data bytes are staged in a 16-entry line buffer and are committed to the store when the master sends a stop. A timed programming interval then follows. During that interval the slave does not answer at all, so a master can learn that the interval is over by polling with its device byte. A protect input blocks all writes. Reads return bytes from an internal 11-bit pointer.

The bus has no streaming port and no back-pressure. The master paces every bit with SCL, and the slave never holds SCL low. The only signals the slave uses to refuse a transfer are the acknowledge bit and the busy status pin.

Top module: `eep_twowire_slave`

## Requirements
- R1: The device byte is received MSB first and is laid out as bits 7..4 = 1010, bits 3..1 = page select, bit 0 = direction (0 = write). A device byte with that tag is acknowledged by pulling SDA low during the ninth clock. Any other tag gets no acknowledge, and every byte after it is ignored until the next start.
- R2: In a write, the byte after the device byte is the word address. Each following byte is data. The slave acknowledges every one of these bytes.
- R3: After each data byte only the low 4 bits of the 11-bit pointer advance. The page select bits and the upper 4 word bits stay frozen, so bytes outside the addressed 16-byte line are left unchanged.
- R4: If more than 16 data bytes are sent, the low bits wrap around and earlier locations in the line are overwritten. Only the last value sent to each location is stored.
- R5: A stop commits the buffered bytes to the store. A stop that comes before any complete data byte starts no programming interval.
- R6: After a commit, `busy_o` is high for exactly PROG_CYCLES clocks. While it is high the slave never pulls SDA low, and it acknowledges nothing, not even its own device byte.
- R7: Once `busy_o` has dropped, a start followed by a matching device byte is acknowledged again, whatever the direction bit.
- R8: While `wp_i` is high, data bytes are still acknowledged but are dropped. The store does not change and `busy_o` stays low after the stop.
- R9: With the direction bit at 1, the slave sends the byte at the pointer MSB first. It then advances the full 11-bit pointer, wrapping from 2047 to 0. It keeps sending while the master acknowledges, and it releases SDA after a not-acknowledge. A stop always releases SDA.
- R10: After reset, SDA is released, `busy_o` is low, every location reads 0xFF, and the pointer is 0.
- R11: After a write, the pointer holds the in-line address that follows the last data byte, so a current-address read starts from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| wp_i | input | 1 | Write protect; high blocks all writes |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| busy_o | output | 1 | High during the programming interval |

## Verification
A table of single-byte writes is spread over the pages. It includes the lowest and highest locations. Each entry is read back through a dummy write that sets the pointer, which separates page decoding from word decoding. An 18-byte burst that starts two bytes before the end of a line shows, all at once, the wrap of the low bits, the overwrite of early bytes, the frozen upper bits and the pointer left behind. Polls sent during and after the programming interval separate the silent period from normal service. Separate runs with protect raised and with a foreign tag show bytes that are acknowledged but dropped, as distinct from bytes that are refused.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WADR,
    PH_WDAT,
    PH_RD
  } phase_t;

  localparam logic [3:0] DEV_TAG = 4'b1010;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // data edge while the clock line stays high marks a frame boundary
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_page_latch.sv
module eep_page_latch #(
  parameter int LW = 4,
  localparam int NLAT = 1 << LW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LW-1:0]     idx,
  input  logic [7:0]        wdata,
  input  logic              clr,
  output logic [8*NLAT-1:0] bytes_flat,
  output logic [NLAT-1:0]   valid
);
  logic [7:0] bytes_q [NLAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= '0;
      for (int i = 0; i < NLAT; i++) bytes_q[i] <= 8'h00;
    end else if (clr) begin
      valid <= '0;
    end else if (we) begin
      bytes_q[idx] <= wdata;
      valid[idx]   <= 1'b1;
    end
  end

  for (genvar g = 0; g < NLAT; g++) begin : g_pack
    assign bytes_flat[g*8 +: 8] = bytes_q[g];
  end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int AW          = 11,
  parameter int LW          = 4,
  parameter int PROG_CYCLES = 2000,
  localparam int DEPTH = 1 << AW,
  localparam int NLAT  = 1 << LW,
  localparam int RW    = AW - LW,
  localparam int CW    = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [RW-1:0]     row,
  input  logic [8*NLAT-1:0] lat_flat,
  input  logic [NLAT-1:0]   lat_valid,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy
);
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int j = 0; j < NLAT; j++) begin
        if (lat_valid[j]) mem[{row, LW'(j)}] <= lat_flat[j*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (commit)       cnt <= CW'(PROG_CYCLES);
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign busy    = (cnt != '0);
  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eep_engine.sv
module eep_engine
  import eep_pkg::*;
#(
  parameter int AW = 11,
  parameter int PW = 3,
  parameter int LW = 4,
  localparam int WA = AW - PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          wp_i,
  input  logic          busy,
  input  logic          lat_any,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic [AW-1:0] ptr,
  output logic          lat_we,
  output logic [LW-1:0] lat_idx,
  output logic [7:0]    lat_data,
  output logic          lat_clr,
  output logic          commit
);
  phase_t        phase;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, txd;
  logic          ackph, rw, mack;
  logic [PW-1:0] dev_page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txd      <= '0;
      ackph    <= 1'b0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      dev_page <= '0;
      sda_oe   <= 1'b0;
      ptr      <= '0;
      lat_we   <= 1'b0;
      lat_idx  <= '0;
      lat_data <= '0;
      lat_clr  <= 1'b0;
      commit   <= 1'b0;
    end else begin
      lat_we  <= 1'b0;
      lat_clr <= 1'b0;
      commit  <= 1'b0;
      if (busy) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
        ackph  <= 1'b0;
        bitcnt <= '0;
      end else if (start_ev) begin
        phase   <= PH_DEV;
        bitcnt  <= '0;
        ackph   <= 1'b0;
        sda_oe  <= 1'b0;
        lat_clr <= 1'b1;
      end else if (stop_ev) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
        ackph  <= 1'b0;
        if (lat_any) commit <= 1'b1;
      end else begin
        case (phase)
          PH_DEV, PH_WADR, PH_WDAT: begin
            if (scl_rise && !ackph && bitcnt < 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && !ackph && bitcnt == 4'd8) begin
              ackph <= 1'b1;
              case (phase)
                PH_DEV: begin
                  if (shreg[7:4] == DEV_TAG) begin
                    sda_oe   <= 1'b1;
                    rw       <= shreg[0];
                    dev_page <= shreg[PW:1];
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                PH_WADR: begin
                  sda_oe <= 1'b1;
                  ptr    <= {dev_page, shreg[WA-1:0]};
                end
                PH_WDAT: begin
                  sda_oe <= 1'b1;
                  if (!wp_i) begin
                    lat_we   <= 1'b1;
                    lat_idx  <= ptr[LW-1:0];
                    lat_data <= shreg;
                  end
                  ptr[LW-1:0] <= ptr[LW-1:0] + LW'(1);
                end
                default: ;
              endcase
            end else if (scl_fall && ackph) begin
              ackph  <= 1'b0;
              bitcnt <= '0;
              sda_oe <= 1'b0;
              case (phase)
                PH_DEV: begin
                  if (rw) begin
                    phase  <= PH_RD;
                    txd    <= rd_data;
                    sda_oe <= ~rd_data[7];
                  end else begin
                    phase <= PH_WADR;
                  end
                end
                PH_WADR: phase <= PH_WDAT;
                default: ;
              endcase
            end
          end
          PH_RD: begin
            if (scl_rise) begin
              if (bitcnt < 4'd8) begin
                bitcnt <= bitcnt + 4'd1;
              end else if (bitcnt == 4'd8) begin
                mack   <= ~sda_s;
                bitcnt <= 4'd9;
              end
            end else if (scl_fall) begin
              if (bitcnt != 4'd0 && bitcnt < 4'd8) begin
                txd    <= {txd[6:0], 1'b0};
                sda_oe <= ~txd[6];
              end else if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + AW'(1);
              end else if (bitcnt == 4'd9) begin
                if (mack) begin
                  txd    <= rd_data;
                  sda_oe <= ~rd_data[7];
                  bitcnt <= '0;
                end else begin
                  phase  <= PH_IDLE;
                  sda_oe <= 1'b0;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eep_twowire_slave.sv
module eep_twowire_slave #(
  parameter int PW          = 3,
  parameter int WA          = 8,
  parameter int LW          = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PROG_CYCLES = 2000,
  localparam int AW   = PW + WA,
  localparam int NLAT = 1 << LW
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o,
  output logic busy_o
);
  logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [AW-1:0]     ptr;
  logic              lat_we, lat_clr, commit, lat_any;
  logic [LW-1:0]     lat_idx;
  logic [7:0]        lat_data, rd_data;
  logic [8*NLAT-1:0] lat_flat;
  logic [NLAT-1:0]   lat_valid;

  eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  eep_engine #(.AW(AW), .PW(PW), .LW(LW)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .wp_i(wp_i), .busy(busy_o), .lat_any(lat_any), .rd_data(rd_data),
    .sda_oe(sda_oe_o), .ptr(ptr), .lat_we(lat_we), .lat_idx(lat_idx),
    .lat_data(lat_data), .lat_clr(lat_clr), .commit(commit)
  );

  eep_page_latch #(.LW(LW)) u_lat (
    .clk(clk), .rst_n(rst_n), .we(lat_we), .idx(lat_idx),
    .wdata(lat_data), .clr(lat_clr | commit),
    .bytes_flat(lat_flat), .valid(lat_valid)
  );

  assign lat_any = |lat_valid;

  eep_array #(.AW(AW), .LW(LW), .PROG_CYCLES(PROG_CYCLES)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit), .row(ptr[AW-1:LW]),
    .lat_flat(lat_flat), .lat_valid(lat_valid), .rd_addr(ptr),
    .rd_data(rd_data), .busy(busy_o)
  );
endmodule

// File: rtl/eep_checker.sv
module eep_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sda_oe,
  input logic commit,
  input logic stop_ev,
  input logic lat_we,
  input logic wp_i,
  input logic lat_any
);
  p_quiet_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  p_commit_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  p_busy_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit));

  p_commit_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> lat_any);

  p_wp_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lat_we |-> $past(!wp_i));

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);
endmodule

bind eep_twowire_slave eep_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_o), .sda_oe(sda_oe_o),
  .commit(commit), .stop_ev(stop_ev), .lat_we(lat_we), .wp_i(wp_i),
  .lat_any(lat_any)
);

// File: tb/sim_eep_twowire_slave.sv
module sim_eep_twowire_slave;
  localparam int PROG = 600;
  localparam int Q    = 10;
  // {page, word address, data}
  localparam logic [18:0] VEC [6] = '{
    {3'd0, 8'h00, 8'h11}, {3'd7, 8'hFF, 8'h22}, {3'd3, 8'h5A, 8'hA5},
    {3'd5, 8'h10, 8'h00}, {3'd1, 8'h0F, 8'h3C}, {3'd6, 8'h80, 8'h7E}
  };

  logic clk = 1'b0;
  logic rst_n, scl, m_low, wp, sda_line;
  logic sda_oe, busy;
  int   n_chk = 0, n_bad = 0, run = 0, last_run = 0;

  always #5 clk = ~clk;
  assign sda_line = ~(m_low | sda_oe);

  eep_twowire_slave #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .wp_i(wp),
    .sda_oe_o(sda_oe), .busy_o(busy)
  );

  always @(negedge clk) begin
    if (busy) run <= run + 1;
    else if (run != 0) begin last_run <= run; run <= 0; end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    m_low = 1'b0; scl = 1'b1; wq(Q);
    m_low = 1'b1; wq(2*Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    m_low = 1'b0; wq(2*Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    end
    m_low = 1'b0; wq(Q); scl = 1'b1; wq(Q);
    ack = ~sda_line; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl = 1'b0;
    end
    m_low = mack; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    m_low = 1'b0;
  endtask

  function automatic logic [7:0] dev(input logic [2:0] pg, input logic r);
    return {4'b1010, pg, r};
  endfunction

  task automatic set_ptr(input logic [2:0] pg, input logic [7:0] wd);
    logic a;
    bus_start(); put_byte(dev(pg, 1'b0), a); put_byte(wd, a); bus_stop();
  endtask

  task automatic read_one(output logic [7:0] d);
    logic a;
    bus_start(); put_byte(dev(3'd0, 1'b1), a); get_byte(1'b0, d); bus_stop();
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 5000) begin wq(1); g++; end
  endtask

  initial begin
    logic a0, a1, a2;
    logic [7:0] d;
    rst_n = 1'b0; scl = 1'b1; m_low = 1'b0; wp = 1'b0;
    wq(5); rst_n = 1'b1; wq(5);

    // R10 reset state
    chk("R10 sda released", sda_oe, 0);
    chk("R10 busy low", busy, 0);
    read_one(d); chk("R10 erased at 0", d, 8'hFF);

    // table walk
    for (int i = 0; i < 6; i++) begin
      logic [2:0] pg; logic [7:0] wd, dt;
      {pg, wd, dt} = VEC[i];
      bus_start(); put_byte(dev(pg, 1'b0), a0); put_byte(wd, a1); put_byte(dt, a2); bus_stop();
      chk("R1 device ack", a0, 1);
      chk("R2 word and data ack", {a1, a2}, 2'b11);
      wq(2); chk("R6 busy after stop", busy, 1);
      bus_start(); put_byte(dev(pg, i[0]), a0); bus_stop();
      chk("R6 no ack while busy", a0, 0);
      wait_idle(); wq(3);
      chk("R6 busy length", last_run, PROG);
      bus_start(); put_byte(dev(pg, 1'b0), a0); bus_stop();
      chk("R7 ack after busy", a0, 1);
      wq(4); chk("R5 empty stop no busy", busy, 0);
      set_ptr(pg, wd); read_one(d);
      chk("R9 readback", d, dt);
    end

    // R9 full pointer wrap 2047 -> 0
    set_ptr(3'd7, 8'hFF);
    bus_start(); put_byte(dev(3'd0, 1'b1), a0);
    get_byte(1'b1, d); chk("R9 last location", d, 8'h22);
    get_byte(1'b0, d); chk("R9 wrap to 0", d, 8'h11);
    bus_stop();
    chk("R9 released after nack", sda_oe, 0);

    // R3 R4 R11 burst of 18 from line offset 14
    bus_start(); put_byte(dev(3'd2, 1'b0), a0); put_byte(8'h3E, a1);
    a2 = 1'b1;
    for (int k = 0; k < 18; k++) begin
      logic a; put_byte(8'h40 + 8'(k), a); a2 = a2 & a;
    end
    bus_stop();
    chk("R4 all burst bytes acked", a2, 1);
    wait_idle(); wq(3);
    bus_start(); put_byte(dev(3'd2, 1'b1), a0);
    for (int j = 0; j < 17; j++) begin
      logic [7:0] e;
      get_byte(j < 16, d);
      if (j == 16)      e = 8'hFF;
      else if (j == 14) e = 8'h50;
      else if (j == 15) e = 8'h51;
      else              e = 8'h42 + 8'(j);
      if (j == 0)       chk("R11 pointer after write", d, e);
      else if (j >= 14 && j < 16) chk("R4 overwrite kept last", d, e);
      else              chk("R3 line wrap and frozen upper bits", d, e);
    end
    bus_stop();

    // R8 write protect
    wp = 1'b1;
    bus_start(); put_byte(dev(3'd4, 1'b0), a0); put_byte(8'h20, a1); put_byte(8'h99, a2); bus_stop();
    chk("R8 data acked under protect", a2, 1);
    wq(4); chk("R8 no busy under protect", busy, 0);
    wp = 1'b0;
    set_ptr(3'd4, 8'h20); read_one(d);
    chk("R8 store unchanged", d, 8'hFF);

    // R1 foreign tag
    bus_start(); put_byte(8'hB0, a0); put_byte(8'h00, a1); bus_stop();
    chk("R1 foreign tag refused", a0, 0);
    chk("R1 later bytes ignored", a1, 0);

    // R5 stop right after word address
    set_ptr(3'd1, 8'h0F); wq(4);
    chk("R5 no cycle without data", busy, 0);

    // R10 reset clears store and pointer
    rst_n = 1'b0; wq(3); rst_n = 1'b1; wq(3);
    read_one(d); chk("R10 store erased after reset", d, 8'hFF);

    summary();
  end
endmodule